// File: doc/BRIEF.md
# Multiplexed Event Interrupt Vector Unit

This unit collects a set of peripheral event lines into one summary interrupt request for the main interrupt controller. Each event line owns a pending flag and an enable flag. The pending flags and the enable flags are each packed into register words, and software can read and write those words. Hardware sets a pending flag when its event line pulses. Software can also set or clear pending flags directly.

Software services the summary interrupt by reading a vector register. The read returns a code that names the highest-ranked event that is both pending and enabled, so a handler can index a jump table with it. The read has a side effect: it clears the pending flag of the event it reported. The summary request stays asserted while any pending flag is set. It drops only when the last pending flag has gone.

Top module: `mivc_top`

## Requirements
- R1: While reset is held and after it is released, every pending flag and enable flag is zero, the captured vector code is 0 and the summary output is low.
- R2: An event pulse on line k (0-based) sets pending flag k at the next clock edge. That flag is reported in pending word k/16 at bit k%16. It then stays set until software clears it by a write or by a vector read.
- R3: Register words are selected by address: 0 is enable bits 0-15, 1 is enable bits 16-19, 2 is pending bits 0-15, 3 is pending bits 16-19. Writes take effect at the next edge. Unused upper bits of words 1 and 3 read as zero.
- R4: A vector read strobe captures the code k+1 of the highest-numbered line k that is both pending and enabled, giving codes 01H to 14H. The higher line number wins.
- R5: A vector read with no line both pending and enabled captures code 0. A pending but disabled line is ignored by the selection, and its pending flag is left unchanged.
- R6: A vector read clears the pending flag of the reported line at the same edge that captures the code. A read of code 0 clears nothing.
- R7: If an event pulse for line k arrives in the same cycle as a vector read that reports line k, pending flag k stays set.
- R8: Writing a pending word replaces those pending flags with the written data, setting or clearing them directly. A same-cycle read clear, and then a same-cycle event, take precedence in that order.
- R9: The summary output is high exactly when at least one pending flag is set, whether or not that line is enabled. It falls only once all pending flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | 20 | Event pulses, one per line |
| reg_wr_en | input | 1 | Register word write strobe |
| reg_addr | input | 2 | Register word select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for the selected word |
| vec_rd_stb | input | 1 | Vector register read strobe |
| vec_code_o | output | 8 | Last captured vector code |
| summary_o | output | 1 | Summary pending request to the main controller |

## Verification
The bench builds the unit with its default values: 20 event lines and 16-bit register words. With those values the second word of each pair is only partly used, so the zero-padding of the upper bits is exercised, and the top code 14H can be reached. A behavioural model runs alongside and applies writes, read clears and events in the stated order. Directed sequences hit the ranking, masked-only pending, and the collision of an event with its own read clear. Random traffic then mixes all three actions.

// File: rtl/mivc_pkg.sv
package mivc_pkg;
  function automatic int unsigned words_for(int unsigned n, int unsigned w);
    return (n + w - 1) / w;
  endfunction
endpackage

// File: rtl/mivc_rst_sync.sv
module mivc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/mivc_src_bank.sv
module mivc_src_bank #(
  parameter int unsigned NUM_SRC   = 20,
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned NUM_WORDS = 2,
  parameter int unsigned ADDR_W    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [WORD_W-1:0]  wr_data,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [NUM_SRC-1:0] mask_o
);
  logic [NUM_SRC-1:0] pend_q, pend_d, mask_q, mask_d;
  logic [NUM_SRC-1:0] mask_we, pend_we, wr_bit;
  logic               pend_ce, mask_ce;

  // per-line write decode: line k sits in word k/WORD_W, bit k%WORD_W
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_dec
    localparam int unsigned WRD = k / WORD_W;
    localparam int unsigned BIT = k % WORD_W;
    assign mask_we[k] = wr_en && (wr_addr == ADDR_W'(WRD));
    assign pend_we[k] = wr_en && (wr_addr == ADDR_W'(NUM_WORDS + WRD));
    assign wr_bit[k]  = wr_data[BIT];
  end

  // next state: write, then read clear, then event
  always_comb begin
    pend_d = pend_q;
    mask_d = mask_q;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (mask_we[k]) mask_d[k] = wr_bit[k];
      if (pend_we[k]) pend_d[k] = wr_bit[k];
      if (clr_i[k])   pend_d[k] = 1'b0;
      if (evt_i[k])   pend_d[k] = 1'b1;
    end
  end

  assign pend_ce = (|evt_i) || (|clr_i) || (|pend_we);
  assign mask_ce = |mask_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      if (pend_ce) pend_q <= pend_d;
      if (mask_ce) mask_q <= mask_d;
    end
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_chk
    p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[k] |=> pend_q[k]);
    p_pend_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q[k] && !clr_i[k] && !pend_we[k] |=> pend_q[k]);
    p_rd_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i[k] && !evt_i[k] |=> !pend_q[k]);
    p_evt_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i[k] && evt_i[k] |=> pend_q[k]);
  end
endmodule

// File: rtl/mivc_prio_enc.sv
module mivc_prio_enc #(
  parameter int unsigned NUM_SRC = 20,
  parameter int unsigned IDX_W   = 5
) (
  input  logic [NUM_SRC-1:0] req_i,
  output logic               valid_o,
  output logic [IDX_W-1:0]   idx_o
);
  // ascending scan: the last set bit seen is the highest ranked
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign valid_o = |req_i;
endmodule

// File: rtl/mivc_vector_reg.sv
module mivc_vector_reg #(
  parameter int unsigned NUM_SRC = 20,
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned CODE_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_stb_i,
  input  logic               sel_valid_i,
  input  logic [IDX_W-1:0]   sel_idx_i,
  output logic [CODE_W-1:0]  code_o,
  output logic [NUM_SRC-1:0] clr_o
);
  logic [CODE_W-1:0] code_q, code_d;
  logic              code_ce;

  assign code_d  = sel_valid_i ? (CODE_W'(sel_idx_i) + CODE_W'(1)) : '0;
  assign code_ce = rd_stb_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (code_ce) code_q <= code_d;
  end

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_clr
    assign clr_o[k] = rd_stb_i && sel_valid_i && (sel_idx_i == IDX_W'(k));
  end

  assign code_o = code_q;

  p_code_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_i && sel_valid_i |=> (code_q != '0) && (code_q <= CODE_W'(NUM_SRC)));
endmodule

// File: rtl/mivc_top.sv
module mivc_top #(
  parameter int unsigned NUM_SRC   = 20,
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned CODE_W    = 8,
  parameter int unsigned NUM_WORDS = mivc_pkg::words_for(NUM_SRC, WORD_W),
  parameter int unsigned ADDR_W    = $clog2(2 * NUM_WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               reg_wr_en,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [WORD_W-1:0]  reg_wdata,
  output logic [WORD_W-1:0]  reg_rdata,
  input  logic               vec_rd_stb,
  output logic [CODE_W-1:0]  vec_code_o,
  output logic               summary_o
);
  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int unsigned PAD_W = NUM_WORDS * WORD_W;

  logic               rst_i_n;
  logic [NUM_SRC-1:0] pend, mask, req, clr;
  logic               sel_valid;
  logic [IDX_W-1:0]   sel_idx;
  logic [PAD_W-1:0]   pend_pad, mask_pad;

  mivc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  mivc_src_bank #(
    .NUM_SRC   (NUM_SRC),
    .WORD_W    (WORD_W),
    .NUM_WORDS (NUM_WORDS),
    .ADDR_W    (ADDR_W)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .evt_i   (evt_i),
    .clr_i   (clr),
    .wr_en   (reg_wr_en),
    .wr_addr (reg_addr),
    .wr_data (reg_wdata),
    .pend_o  (pend),
    .mask_o  (mask)
  );

  assign req = pend & mask;

  mivc_prio_enc #(
    .NUM_SRC (NUM_SRC),
    .IDX_W   (IDX_W)
  ) u_enc (
    .req_i   (req),
    .valid_o (sel_valid),
    .idx_o   (sel_idx)
  );

  mivc_vector_reg #(
    .NUM_SRC (NUM_SRC),
    .IDX_W   (IDX_W),
    .CODE_W  (CODE_W)
  ) u_vec (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .rd_stb_i    (vec_rd_stb),
    .sel_valid_i (sel_valid),
    .sel_idx_i   (sel_idx),
    .code_o      (vec_code_o),
    .clr_o       (clr)
  );

  // readback, zero-padded to whole words
  assign pend_pad = PAD_W'(pend);
  assign mask_pad = PAD_W'(mask);

  always_comb begin
    reg_rdata = '0;
    for (int w = 0; w < int'(NUM_WORDS); w++) begin
      if (reg_addr == ADDR_W'(w))             reg_rdata = mask_pad[w*WORD_W +: WORD_W];
      if (reg_addr == ADDR_W'(NUM_WORDS + w)) reg_rdata = pend_pad[w*WORD_W +: WORD_W];
    end
  end

  assign summary_o = |pend;

  p_highest_r4: assert property (@(posedge clk) disable iff (!rst_i_n)
    sel_valid |-> req[sel_idx] && ((req >> sel_idx) == NUM_SRC'(1)));
  p_idle_code_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    vec_rd_stb && !(|req) |=> vec_code_o == '0);
  p_summary_hold_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    summary_o && !vec_rd_stb && !reg_wr_en |=> summary_o);
  p_summary_rise_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (|evt_i) |=> summary_o);
endmodule

// File: tb/mivc_top_test.sv
module mivc_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [19:0] evt_i;
  logic        reg_wr_en;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        vec_rd_stb;
  logic [7:0]  vec_code_o;
  logic        summary_o;

  int checks = 0;
  int fails  = 0;
  bit model_on = 1'b0;

  logic [19:0] m_pend = '0;
  logic [19:0] m_mask = '0;
  int          m_vec  = 0;

  always #10 clk = ~clk;

  mivc_top uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt_i),
    .reg_wr_en  (reg_wr_en),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .vec_rd_stb (vec_rd_stb),
    .vec_code_o (vec_code_o),
    .summary_o  (summary_o)
  );

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference: write, then read clear, then events
  always @(posedge clk) begin
    if (model_on) begin
      logic [19:0] nxt;
      int top;
      top = -1;
      for (int i = 0; i < 20; i++) if (m_pend[i] && m_mask[i]) top = i;
      nxt = m_pend;
      if (reg_wr_en) begin
        case (reg_addr)
          2'd0: m_mask[15:0]  = reg_wdata;
          2'd1: m_mask[19:16] = reg_wdata[3:0];
          2'd2: nxt[15:0]     = reg_wdata;
          default: nxt[19:16] = reg_wdata[3:0];
        endcase
      end
      if (vec_rd_stb) begin
        m_vec = top + 1;
        if (top >= 0) nxt[top] = 1'b0;
      end
      nxt = nxt | evt_i;
      m_pend = nxt;
    end
  end

  function automatic int model_rd(logic [1:0] a);
    case (a)
      2'd0: return int'(m_mask[15:0]);
      2'd1: return int'(m_mask[19:16]);
      2'd2: return int'(m_pend[15:0]);
      default: return int'(m_pend[19:16]);
    endcase
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (model_on) begin
      chk("R4 model vector", int'(vec_code_o), m_vec);
      chk("R9 model summary", int'(summary_o), int'(|m_pend));
      chk("R3 model readback", int'(reg_rdata), model_rd(reg_addr));
    end
  endtask

  task automatic rd(logic [1:0] a, int exp, string tag);
    reg_addr = a;
    #1;
    chk(tag, int'(reg_rdata), exp);
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr_en = 1'b0;
  endtask

  task automatic pulse(logic [19:0] e);
    evt_i = e;
    tick();
    evt_i = '0;
  endtask

  task automatic vread(logic [19:0] e);
    vec_rd_stb = 1'b1; evt_i = e;
    tick();
    vec_rd_stb = 1'b0; evt_i = '0;
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; evt_i = '0; reg_wr_en = 1'b0; reg_addr = '0;
    reg_wdata = '0; vec_rd_stb = 1'b0;
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk("R1 code in reset", int'(vec_code_o), 0);
    chk("R1 summary in reset", int'(summary_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_on = 1'b1;
    for (int a = 0; a < 4; a++) rd(2'(a), 0, "R1 word after reset");

    // R3: enable words and padding
    wr(2'd0, 16'h00FF);
    wr(2'd1, 16'hFFFF);
    rd(2'd0, 16'h00FF, "R3 enable low");
    rd(2'd1, 16'h000F, "R3 enable high padded");

    // R2: events set pending
    pulse(20'h20008);
    rd(2'd2, 16'h0008, "R2 pending low");
    rd(2'd3, 16'h0002, "R2 pending high");
    chk("R9 summary up", int'(summary_o), 1);

    // R4 / R6: ranking and read clear
    vread('0);
    chk("R4 highest code", int'(vec_code_o), 8'h12);
    rd(2'd3, 0, "R6 reported line cleared");
    rd(2'd2, 16'h0008, "R6 other line kept");
    vread('0);
    chk("R4 next code", int'(vec_code_o), 4);
    chk("R9 summary falls", int'(summary_o), 0);
    vread('0);
    chk("R5 empty code", int'(vec_code_o), 0);

    // R5: disabled pending line ignored
    pulse(20'h00400);
    vread('0);
    chk("R5 masked ignored", int'(vec_code_o), 0);
    rd(2'd2, 16'h0400, "R5 masked pending kept");
    chk("R9 summary with masked", int'(summary_o), 1);

    // R8: direct pending writes
    wr(2'd2, 16'h0000);
    chk("R8 clear by write", int'(summary_o), 0);
    wr(2'd3, 16'h0008);
    vread('0);
    chk("R8 set by write, R4 top code", int'(vec_code_o), 8'h14);

    // R7: event beats its own read clear
    pulse(20'h00020);
    vread(20'h00020);
    chk("R7 code", int'(vec_code_o), 6);
    rd(2'd2, 16'h0020, "R7 pending kept");

    // mixed random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      evt_i      = 20'($urandom & $urandom & $urandom & $urandom);
      vec_rd_stb = ($urandom % 4) == 0;
      reg_wr_en  = ($urandom % 12) == 0;
      reg_addr   = 2'($urandom);
      reg_wdata  = 16'($urandom);
      tick();
    end
    evt_i = '0; vec_rd_stb = 1'b0; reg_wr_en = 1'b0;
    tick();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule